// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two unsigned operands and a carry-in with no registers on any path. The operands are split into 4-bit slices. Each slice forms a generate and a propagate term for every bit. From those it forms its own internal carries, its sum bits and a slice-level generate/propagate pair.

A second lookahead stage takes the slice-level pairs and the carry-in. It computes every slice boundary carry at once as a sum of products, so no carry has to pass from one slice to the next. A parameter swaps that stage for a chain in which each slice's carry-out feeds the next slice. This gives a ripple-of-slices build, for example at 32 bits, that must agree bit for bit with the lookahead build. The boundary carries are also brought out, so carry behaviour can be observed one slice at a time.

Top module: `cla_adder`

## Requirements
- R1: `{c_out, sum}` equals the unsigned value `x + y + c_in`, carried to WIDTH+1 bits, for every input combination.
- R2: When the two 4-bit operand fields of a slice add to more than 15, that slice's boundary carry (`grp_c` bit k for slice k, where slice k covers bits 4k+3..4k) is 1 whatever carry enters the slice.
- R3: When a slice's operand fields add to exactly 15, its boundary carry equals the carry entering it (`c_in` for slice 0, `grp_c` bit k-1 otherwise).
- R4: When a slice's operand fields add to less than 15, its boundary carry is 0 whatever carry enters the slice.
- R5: `grp_c` bit k equals bit 4(k+1) of the sum of the low 4(k+1) bits of `x`, the low 4(k+1) bits of `y`, and `c_in`.
- R6: All-ones plus one (x all ones, y zero, c_in 1, or x all ones and y = 1 with c_in 0) gives `sum` = 0 and `c_out` = 1.
- R7: With both operands zero, `sum` equals `c_in` and `c_out` is 0.
- R8: With LOOKAHEAD = 0 (slices chained), the results equal those of LOOKAHEAD = 1 for the same operands, including at WIDTH = 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the result |
| c_out | output | 1 | Carry out of the top bit |
| grp_c | output | WIDTH/4 | Carry out of each 4-bit slice, bit k for slice k |

## Verification
In one evaluation, a carry generated in a low slice can have to cross every upper slice, each of which only propagates, at the same moment that the carry-in must also reach the top. The all-propagate operands with `c_in` = 1 provoke this case, as do operands where slice 0 generates and all higher slices sit at a field sum of exactly 15. The outcome is judged on `c_out`, `sum` and every `grp_c` bit against values the bench computes from the requirements. Random operands then mix generating, propagating and killing slices, and the 16-bit lookahead, 32-bit lookahead and 32-bit chained builds are compared against the same reference.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int GRP_W = 4;
  localparam int MAXW  = 64;

  // Carry leaving position 'top': the sum of products of generates, each
  // gated by the propagates above it, plus all propagates gated with cin.
  function automatic logic sop_carry(input logic [MAXW-1:0] g,
                                     input logic [MAXW-1:0] p,
                                     input logic            cin,
                                     input int              top);
    logic acc;
    logic run;
    acc = 1'b0;
    run = 1'b1;
    for (int j = MAXW - 1; j >= 0; j--) begin
      if (j <= top) begin
        acc = acc | (run & g[j]);
        run = run & p[j];
      end
    end
    return acc | (run & cin);
  endfunction
endpackage

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int W = GRP_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         gg,
  output logic         gp,
  output logic         cout
);
  logic [W-1:0]    g;
  logic [W-1:0]    p;
  logic [W:0]      c;
  logic [MAXW-1:0] g_x;
  logic [MAXW-1:0] p_x;

  always_comb begin
    g   = a & b;
    p   = a ^ b;
    g_x = MAXW'(g);
    p_x = MAXW'(p);
  end

  // every internal carry formed directly from cin and the bit terms
  always_comb begin
    c[0] = cin;
    for (int i = 0; i < W; i++) begin
      c[i+1] = sop_carry(g_x, p_x, cin, i);
    end
  end

  always_comb begin
    s    = p ^ c[W-1:0];
    gg   = sop_carry(g_x, p_x, 1'b0, W - 1);
    gp   = &p;
    cout = gg | (gp & cin);
  end

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      p_grp_cout_r5: assert (c[W] == cout)
        else $error("slice top carry disagrees with slice terms");
      if (gg)
        p_grp_gen_r2: assert (c[W] == 1'b1)
          else $error("generating slice did not carry");
      if (gp)
        p_grp_prop_r3: assert (c[W] == cin)
          else $error("propagating slice did not pass carry");
      if (!gg && !gp)
        p_grp_kill_r4: assert (c[W] == 1'b0)
          else $error("killing slice produced a carry");
    end
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int NG = 4
) (
  input  logic [NG-1:0] gg,
  input  logic [NG-1:0] gp,
  input  logic          cin,
  output logic [NG:0]   carry
);
  logic [MAXW-1:0] gg_x;
  logic [MAXW-1:0] gp_x;

  always_comb begin
    gg_x     = MAXW'(gg);
    gp_x     = MAXW'(gp);
    carry[0] = cin;
    for (int k = 0; k < NG; k++) begin
      carry[k+1] = sop_carry(gg_x, gp_x, cin, k);
    end
  end

  // the parallel form must match a step-by-step chain of slice carries
  always_comb begin
    if (!$isunknown({gg, gp, cin})) begin
      for (int k = 0; k < NG; k++) begin
        p_la_chain_r5: assert (carry[k+1] == (gg[k] | (gp[k] & carry[k])))
          else $error("lookahead carry %0d disagrees with chained form", k);
      end
    end
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter bit LOOKAHEAD = 1'b1
) (
  input  logic [WIDTH-1:0]       x,
  input  logic [WIDTH-1:0]       y,
  input  logic                   c_in,
  output logic [WIDTH-1:0]       sum,
  output logic                   c_out,
  output logic [WIDTH/GRP_W-1:0] grp_c
);
  localparam int NG = WIDTH / GRP_W;

  logic [NG-1:0] grp_gg;
  logic [NG-1:0] grp_gp;
  logic [NG-1:0] grp_co;
  logic [NG:0]   grp_ci;

  for (genvar k = 0; k < NG; k++) begin : g_slice
    cla_group #(.W(GRP_W)) u_slice (
      .a   (x[k*GRP_W +: GRP_W]),
      .b   (y[k*GRP_W +: GRP_W]),
      .cin (grp_ci[k]),
      .s   (sum[k*GRP_W +: GRP_W]),
      .gg  (grp_gg[k]),
      .gp  (grp_gp[k]),
      .cout(grp_co[k])
    );
  end

  if (LOOKAHEAD) begin : g_la
    cla_lookahead #(.NG(NG)) u_la (
      .gg   (grp_gg),
      .gp   (grp_gp),
      .cin  (c_in),
      .carry(grp_ci)
    );
  end else begin : g_ripple
    always_comb begin
      grp_ci[0] = c_in;
      for (int k = 0; k < NG; k++) grp_ci[k+1] = grp_co[k];
    end
  end

  always_comb begin
    grp_c = grp_ci[NG:1];
    c_out = grp_ci[NG];
  end

  always_comb begin
    if (!$isunknown({x, y, c_in})) begin
      p_result_r1: assert ({c_out, sum} ==
                           ({1'b0, x} + {1'b0, y} + (WIDTH+1)'(c_in)))
        else $error("sum mismatch");
      for (int k = 0; k < NG; k++) begin
        p_link_r8: assert (grp_co[k] == grp_ci[k+1])
          else $error("slice %0d carry-out and next carry-in disagree", k);
      end
    end
  end

  initial begin
    p_width_r1: assert (WIDTH % GRP_W == 0 && NG <= MAXW)
      else $error("WIDTH must be a multiple of the slice width");
  end
endmodule

// File: tb/cla_adder_bench.sv
module cla_adder_bench;
  logic clk;
  int   n_chk;
  int   n_fail;
  bit   done;

  logic [15:0] x16, y16, s16;
  logic [31:0] x32, y32, sl32, sr32;
  logic        cin, co16, col32, cor32;
  logic [3:0]  gc16;
  logic [7:0]  gcl32, gcr32;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  cla_adder u_cla_adder (.x(x16), .y(y16), .c_in(cin), .sum(s16), .c_out(co16), .grp_c(gc16));
  cla_adder #(.WIDTH(32), .LOOKAHEAD(1'b1)) u_cla_adder_l32 (
    .x(x32), .y(y32), .c_in(cin), .sum(sl32), .c_out(col32), .grp_c(gcl32));
  cla_adder #(.WIDTH(32), .LOOKAHEAD(1'b0)) u_cla_adder_r32 (
    .x(x32), .y(y32), .c_in(cin), .sum(sr32), .c_out(cor32), .grp_c(gcr32));

  function automatic logic [16:0] ref16(logic [15:0] a, logic [15:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + 17'(c);
  endfunction
  function automatic logic [32:0] ref32(logic [31:0] a, logic [31:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + 33'(c);
  endfunction
  function automatic logic [7:0] refgc(logic [31:0] a, logic [31:0] b, logic c, int ng);
    logic [7:0]  r;
    logic [32:0] t;
    r = '0;
    for (int k = 0; k < ng; k++) begin
      logic [31:0] m;
      m = (k == 7) ? 32'hFFFF_FFFF : ((32'd1 << (4*(k+1))) - 32'd1);
      t = {1'b0, a & m} + {1'b0, b & m} + 33'(c);
      r[k] = t[4*(k+1)];
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] a, logic [15:0] b, logic c);
    @(posedge clk);
    x16 = a; y16 = b; cin = c;
    x32 = {b, a}; y32 = {a, b};
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [16:0] e16;
    logic [32:0] e32;
    logic [7:0]  g16, g32;
    e16 = ref16(x16, y16, cin);
    e32 = ref32(x32, y32, cin);
    g16 = refgc({16'h0, x16}, {16'h0, y16}, cin, 4);
    g32 = refgc(x32, y32, cin, 8);
    check({co16, s16} == e16, {"R1 ", tag}, 64'({co16, s16}), 64'(e16));
    check(gc16 == g16[3:0], {"R5 ", tag}, 64'(gc16), 64'(g16[3:0]));
    check({col32, sl32} == e32, {"R1 w32 ", tag}, 64'({col32, sl32}), 64'(e32));
    check({cor32, sr32} == {col32, sl32} && gcr32 == gcl32, {"R8 ", tag},
          64'({cor32, sr32}), 64'({col32, sl32}));
    check(gcr32 == g32, {"R8 carries ", tag}, 64'(gcr32), 64'(g32));
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    x16 = '0; y16 = '0; cin = 1'b0; x32 = '0; y32 = '0;
    void'($urandom(32'd20240611));

    // R7: zero operands
    drive(16'h0, 16'h0, 1'b0);
    check(s16 == 16'h0 && co16 == 1'b0, "R7 zero cin0", 64'({co16, s16}), 64'h0);
    drive(16'h0, 16'h0, 1'b1);
    check(s16 == 16'h1 && co16 == 1'b0, "R7 zero cin1", 64'({co16, s16}), 64'h1);
    check_all("zero");

    // R6: all ones plus one, two ways
    drive(16'hFFFF, 16'h0000, 1'b1);
    check(s16 == 16'h0 && co16 == 1'b1 && gc16 == 4'hF, "R6 prop cin",
          64'({gc16, co16, s16}), 64'h1_0000 | 64'hF_0000 << 1);
    check_all("allprop");
    drive(16'hFFFF, 16'h0001, 1'b0);
    check(s16 == 16'h0 && co16 == 1'b1, "R6 plus one", 64'({co16, s16}), 64'h1_0000);
    check_all("plusone");

    // R2: slice 0 generates (9+9) for either carry-in
    drive(16'h0009, 16'h0009, 1'b0);
    check(gc16[0] == 1'b1, "R2 gen cin0", 64'(gc16[0]), 64'h1);
    drive(16'h0009, 16'h0009, 1'b1);
    check(gc16[0] == 1'b1, "R2 gen cin1", 64'(gc16[0]), 64'h1);

    // R3: slice 1 fields sum to 15, passes its incoming carry
    drive(16'h00F8, 16'h0008, 1'b0);
    check(gc16[1] == 1'b1, "R3 pass one", 64'(gc16[1]), 64'h1);
    drive(16'h00F0, 16'h0000, 1'b1);
    check(gc16[1] == 1'b0, "R3 pass zero", 64'(gc16[1]), 64'h0);
    // generate low, propagate through all upper slices at once
    drive(16'hFFF8, 16'h0008, 1'b0);
    check(gc16 == 4'hF && co16 && s16 == 16'h0, "R3 long pass",
          64'({gc16, co16, s16}), 64'h1E_0000 | 64'h1_0000);
    check_all("longpass");

    // R4: slice 1 fields 7+7 kill, even with slice 0 generating
    drive(16'h0078, 16'h0078, 1'b1);
    check(gc16[1] == 1'b0, "R4 kill", 64'(gc16[1]), 64'h0);
    check_all("kill");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if (i % 5 == 0) b = ~a ^ 16'(1 << (i % 16));
      drive(a, b, 1'($urandom));
      check_all("random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule